// File: doc/BRIEF.md
# Serial Memory Command Clock-Count Guard

This block is the command front end of a three-wire serial memory slave. It runs on a system clock and watches a serial clock, a chip select and a data input. While chip select is high, a rising serial-clock edge samples one data bit. Leading zeros are skipped, and the first 1 is taken as the start bit. After it come a 2-bit opcode, an address and, for commands that carry data, a data word. The block counts every serial-clock pulse from the start bit until chip select falls. When chip select falls, it compares that count with the length the decoded command requires.

A command that alters memory or the protection register is committed only when the pulse count is exact, the write latch is enabled and no earlier program cycle is still running. A commit raises a one-cycle strobe carrying the command code, the address and the data. Any other pulse count aborts the command silently. A noise glitch on the serial clock therefore cancels a command, where it would otherwise shift the address and data by one bit. A separate select input chooses the protection-register command space. A disable command in that space sets a sticky lock, but only when the frame just before it was the enable command. While a program cycle runs, the serial output shows busy, provided chip select is high and the lock is clear.

Top module: `serial_cmd_guard`

## Requirements
- R1: After reset, commit_o is 0, and sdo_o is 0 while cs_i is low.
- R2: While cs_i is high and no frame is open, sampled 0 bits are ignored. The first sampled 1 opens the frame and counts as pulse 1. After it come 2 opcode bits, 8 address bits and 16 data bits, each MSB first.
- R3: In the normal space, opcode 01 is a write (cmd_o = 2) and needs exactly 27 pulses. With any other count, no commit is issued.
- R4: Opcode 11 is an erase (cmd_o = 3) and needs exactly 11 pulses. Opcode 00 uses the top two address bits as a sub-code: 00 write-disable, 01 write-all (cmd_o = 5, 27 pulses), 10 erase-all (cmd_o = 6, 11 pulses), 11 write-enable. For commits of 11-pulse commands, data_o is 0.
- R5: The pulse counter saturates at 31, so 40 or 59 pulses never match a length and cause no commit.
- R6: A write-type command commits only after a correctly counted write-enable and before a correctly counted write-disable.
- R7: Opcode 10 (read) never commits, whatever its pulse count.
- R8: A commit is a single-cycle commit_o pulse. It appears in the second system-clock cycle after the one in which cs_i first reads low. It carries cmd_o, the frame's address on addr_o and its data on data_o.
- R9: After a commit, busy lasts BUSY_CYC system clocks starting at the commit edge. sdo_o shows busy only while cs_i is high.
- R10: A write-type command that ends while busy is still running does not commit.
- R11: prot_sel_i is sampled with the start bit. In that space, opcode 00 with address MSBs 11 is enable, and opcode 00 with MSBs 00 is disable. Each needs 11 pulses. A disable sets the sticky lock only if the frame just before it was a valid enable. Once locked, sdo_o never shows busy.
- R12: In the protection space, opcode 01 is a register write (cmd_o = 9) and opcode 11 is a register clear (cmd_o = 10). Each needs 11 pulses and the write-enable latch. Neither commits once the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_i | input | 1 | Chip select, active high |
| sdi_i | input | 1 | Serial data in |
| prot_sel_i | input | 1 | Selects protection-register command space |
| sdo_o | output | 1 | Busy indication on serial output |
| commit_o | output | 1 | One-cycle commit strobe |
| cmd_o | output | 4 | Committed command code |
| addr_o | output | ADDR_W | Committed address |
| data_o | output | DATA_W | Committed data word |

## Verification
A serial data bit is sampled at the first system-clock edge after the bench raises sclk_i. The frame result is registered at the edge that sees cs_i low, so the bench lowers cs_i at a falling clock edge and samples commit_o and its fields at the next falling edge. Busy is loaded at that same edge. The bench therefore raises cs_i immediately after the commit sample, expects sdo_o high in samples 1 through BUSY_CYC-1 and low in sample BUSY_CYC. Pulse-count sweeps compute the expected commit as an exact equality with the command's length.

// File: rtl/scg_pkg.sv
package scg_pkg;
  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_READ    = 4'd1,
    CMD_WRITE   = 4'd2,
    CMD_ERASE   = 4'd3,
    CMD_WDIS    = 4'd4,
    CMD_WRALL   = 4'd5,
    CMD_ERALL   = 4'd6,
    CMD_WEN     = 4'd7,
    CMD_PREAD   = 4'd8,
    CMD_PWRITE  = 4'd9,
    CMD_PCLEAR  = 4'd10,
    CMD_PEN     = 4'd11,
    CMD_PDIS    = 4'd12
  } cmd_e;

  function automatic logic is_write_type(cmd_e c);
    return c inside {CMD_WRITE, CMD_ERASE, CMD_WRALL, CMD_ERALL, CMD_PWRITE, CMD_PCLEAR};
  endfunction

  function automatic logic is_prot_cmd(cmd_e c);
    return c inside {CMD_PWRITE, CMD_PCLEAR};
  endfunction
endpackage

// File: rtl/scg_frame.sv
module scg_frame #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              sdi_i,
  input  logic              prot_sel_i,
  output logic              end_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              prot_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam int               OP_LAST  = 2;
  localparam int               AD_LAST  = OP_LAST + ADDR_W;
  localparam int               DT_LAST  = AD_LAST + DATA_W;

  logic sclk_q, cs_q, active_q;
  logic rise;

  assign rise  = sclk_i & ~sclk_q;
  assign end_o = cs_q & ~cs_i & active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b0;
      active_q <= 1'b0;
      cnt_o    <= '0;
      op_o     <= '0;
      addr_o   <= '0;
      data_o   <= '0;
      prot_o   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_i;
      if (!cs_i) begin
        active_q <= 1'b0;
        cnt_o    <= '0;
      end else if (rise) begin
        if (!active_q) begin
          if (sdi_i) begin
            active_q <= 1'b1;
            cnt_o    <= CNT_W'(1);
            op_o     <= '0;
            addr_o   <= '0;
            data_o   <= '0;
            prot_o   <= prot_sel_i;
          end
        end else begin
          if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
          if (int'(cnt_o) <= OP_LAST)
            op_o <= {op_o[0], sdi_i};
          else if (int'(cnt_o) <= AD_LAST)
            addr_o <= {addr_o[ADDR_W-2:0], sdi_i};
          else if (int'(cnt_o) <= DT_LAST)
            data_o <= {data_o[DATA_W-2:0], sdi_i};
        end
      end
    end
  end

  assert_cnt_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && cs_i) |=> (cnt_o == CNT_MAX || $fell(cs_q)));
endmodule

// File: rtl/scg_decode.sv
module scg_decode
  import scg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [1:0]       op_i,
  input  logic [1:0]       sub_i,
  input  logic             prot_i,
  input  logic [CNT_W-1:0] cnt_i,
  output cmd_e             cmd_o,
  output logic             len_ok_o
);
  localparam int               SHORT_N = 1 + 2 + ADDR_W;
  localparam int               LONG_N  = SHORT_N + DATA_W;
  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT_N);
  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_N);

  always_comb begin
    cmd_o = CMD_NONE;
    if (!prot_i) begin
      unique case (op_i)
        2'b01: cmd_o = CMD_WRITE;
        2'b10: cmd_o = CMD_READ;
        2'b11: cmd_o = CMD_ERASE;
        default: begin
          unique case (sub_i)
            2'b00: cmd_o = CMD_WDIS;
            2'b01: cmd_o = CMD_WRALL;
            2'b10: cmd_o = CMD_ERALL;
            default: cmd_o = CMD_WEN;
          endcase
        end
      endcase
    end else begin
      unique case (op_i)
        2'b01: cmd_o = CMD_PWRITE;
        2'b10: cmd_o = CMD_PREAD;
        2'b11: cmd_o = CMD_PCLEAR;
        default: begin
          if (sub_i == 2'b11)      cmd_o = CMD_PEN;
          else if (sub_i == 2'b00) cmd_o = CMD_PDIS;
          else                     cmd_o = CMD_NONE;
        end
      endcase
    end
  end

  always_comb begin
    unique case (cmd_o)
      CMD_READ, CMD_PREAD, CMD_NONE: len_ok_o = 1'b0;
      CMD_WRITE, CMD_WRALL:          len_ok_o = (cnt_i == LONG_L);
      default:                       len_ok_o = (cnt_i == SHORT_L);
    endcase
  end
endmodule

// File: rtl/scg_ctrl.sv
module scg_ctrl
  import scg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  cmd_e              cmd_i,
  input  logic              len_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              lock_o,
  output logic              commit_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] BUSY_LD = BW'(BUSY_CYC);

  logic [BW-1:0] busy_cnt;
  logic          wen_q, armed_q;
  logic          valid, go;

  assign valid  = end_i & len_ok_i;
  assign go     = valid & is_write_type(cmd_i) & wen_q & ~busy_o
                & ~(is_prot_cmd(cmd_i) & lock_o);
  assign busy_o = (busy_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt <= '0;
      wen_q    <= 1'b0;
      armed_q  <= 1'b0;
      lock_o   <= 1'b0;
      commit_o <= 1'b0;
      cmd_o    <= '0;
      addr_o   <= '0;
      data_o   <= '0;
    end else begin
      commit_o <= go;
      if (go) begin
        busy_cnt <= BUSY_LD;
        cmd_o    <= cmd_i;
        addr_o   <= addr_i;
        data_o   <= data_i;
      end else if (busy_o) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
      if (valid && cmd_i == CMD_WEN)  wen_q <= 1'b1;
      if (valid && cmd_i == CMD_WDIS) wen_q <= 1'b0;
      if (end_i) armed_q <= valid && (cmd_i == CMD_PEN);
      if (valid && cmd_i == CMD_PDIS && armed_q) lock_o <= 1'b1;
    end
  end

  assert_commit_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  assert_commit_wen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wen_q));
  assert_busy_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (busy_cnt == BUSY_LD));
  assert_lock_arm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(armed_q));
  assert_lock_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);
  assert_no_busy_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !$past(busy_o));
endmodule

// File: rtl/serial_cmd_guard.sv
module serial_cmd_guard
  import scg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 5,
  parameter int BUSY_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              sdi_i,
  input  logic              prot_sel_i,
  output logic              sdo_o,
  output logic              commit_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              f_end, f_prot, len_ok, busy, lock;
  logic [CNT_W-1:0]  f_cnt;
  logic [1:0]        f_op;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  cmd_e              dec_cmd;

  scg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .sclk_i, .cs_i, .sdi_i, .prot_sel_i,
    .end_o(f_end), .cnt_o(f_cnt), .op_o(f_op), .addr_o(f_addr),
    .data_o(f_data), .prot_o(f_prot)
  );

  scg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .op_i(f_op), .sub_i(f_addr[ADDR_W-1 -: 2]), .prot_i(f_prot), .cnt_i(f_cnt),
    .cmd_o(dec_cmd), .len_ok_o(len_ok)
  );

  scg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk_i, .rst_ni, .end_i(f_end), .cmd_i(dec_cmd), .len_ok_i(len_ok),
    .addr_i(f_addr), .data_i(f_data), .busy_o(busy), .lock_o(lock),
    .commit_o, .cmd_o, .addr_o, .data_o
  );

  assign sdo_o = cs_i & busy & ~lock;

  assert_commit_csfall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !$past(cs_i));
endmodule

// File: tb/sim_serial_cmd_guard.sv
module sim_serial_cmd_guard;
  localparam int BUSY = 100;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, sdi = 1'b0, psel = 1'b0;
  logic sdo, commit;
  logic [3:0] cmd;
  logic [7:0] addr;
  logic [15:0] data;
  int n_run = 0, n_fail = 0;
  logic got_c;
  logic [3:0] got_cmd;
  logic [7:0] got_a;
  logic [15:0] got_d;

  always #2.5 clk = ~clk;

  serial_cmd_guard #(.BUSY_CYC(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .sdi_i(sdi),
    .prot_sel_i(psel), .sdo_o(sdo), .commit_o(commit), .cmd_o(cmd),
    .addr_o(addr), .data_o(data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  // frame of n pulses from the start bit, preceded by z zero pulses
  task automatic frame(input logic p, input logic [1:0] op, input logic [7:0] a,
                       input logic [15:0] d, input int n, input int z);
    logic [25:0] w;
    w = {op, a, d};
    @(negedge clk); cs = 1'b1; psel = p;
    for (int i = 0; i < z; i++) pulse(1'b0);
    pulse(1'b1);
    for (int j = 0; j < n - 1; j++) pulse(j < 26 ? w[25-j] : 1'b0);
    @(negedge clk); cs = 1'b0; sdi = 1'b0;
    @(negedge clk);
    got_c = commit; got_cmd = cmd; got_a = addr; got_d = data;
  endtask

  task automatic wen();
    frame(1'b0, 2'b00, 8'hC0, 16'h0, 11, 0); idle(BUSY + 5);
  endtask

  initial begin
    int timeout = 0;
    while (timeout < 190000) begin @(posedge clk); timeout++; end
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", timeout);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 commit after reset", int'(commit), 0);
    chk("R1 sdo after reset", int'(sdo), 0);
    rst_n = 1'b1;
    idle(2);

    // R6: write before enable
    frame(1'b0, 2'b01, 8'h12, 16'h3456, 27, 0); idle(BUSY + 5);
    chk("R6 write without enable", int'(got_c), 0);
    wen();

    // R3: write pulse-count sweep
    for (int n = 24; n <= 31; n++) begin
      frame(1'b0, 2'b01, 8'(n * 7), 16'(n * 1031), n, 0);
      chk($sformatf("R3 write n=%0d commit", n), int'(got_c), int'(n == 27));
      if (n == 27) begin
        chk("R3 write cmd", int'(got_cmd), 2);
        chk("R8 write addr", int'(got_a), (n * 7) % 256);
        chk("R8 write data", int'(got_d), (n * 1031) % 65536);
        @(negedge clk);
        chk("R8 strobe one cycle", int'(commit), 0);
      end
      idle(BUSY + 5);
    end

    // R2: leading zeros ignored
    frame(1'b0, 2'b01, 8'hA5, 16'hBEEF, 27, 5);
    chk("R2 leading zeros commit", int'(got_c), 1);
    chk("R2 addr", int'(got_a), 8'hA5);
    chk("R2 data", int'(got_d), 16'hBEEF);
    idle(BUSY + 5);

    // R4: erase sweep
    for (int n = 9; n <= 13; n++) begin
      frame(1'b0, 2'b11, 8'h3C, 16'h0, n, 0);
      chk($sformatf("R4 erase n=%0d", n), int'(got_c), int'(n == 11));
      if (n == 11) begin
        chk("R4 erase cmd", int'(got_cmd), 3);
        chk("R4 erase data zero", int'(got_d), 0);
      end
      idle(BUSY + 5);
    end
    frame(1'b0, 2'b00, 8'h40, 16'h1234, 27, 0);
    chk("R4 write-all commit", int'(got_c), 1);
    chk("R4 write-all cmd", int'(got_cmd), 5);
    chk("R4 write-all data", int'(got_d), 16'h1234);
    idle(BUSY + 5);
    frame(1'b0, 2'b00, 8'h80, 16'h0, 11, 0);
    chk("R4 erase-all cmd", int'(got_c ? got_cmd : 4'd15), 6);
    idle(BUSY + 5);

    // R5: saturation
    frame(1'b0, 2'b01, 8'h01, 16'h0001, 40, 0); idle(BUSY + 5);
    chk("R5 40 pulses", int'(got_c), 0);
    frame(1'b0, 2'b01, 8'h01, 16'h0001, 59, 0); idle(BUSY + 5);
    chk("R5 59 pulses", int'(got_c), 0);

    // R7: reads never commit
    for (int n = 11; n <= 27; n += 8) begin
      frame(1'b0, 2'b10, 8'h55, 16'h0, n, 0); idle(BUSY + 5);
      chk($sformatf("R7 read n=%0d", n), int'(got_c), 0);
    end

    // R9: busy window on sdo
    frame(1'b0, 2'b11, 8'h07, 16'h0, 11, 0);
    chk("R9 erase commit", int'(got_c), 1);
    chk("R9 sdo cs low", int'(sdo), 0);
    cs = 1'b1;
    @(negedge clk);
    chk("R9 busy start", int'(sdo), 1);
    idle(BUSY - 2);
    chk("R9 busy last", int'(sdo), 1);
    @(negedge clk);
    chk("R9 busy end", int'(sdo), 0);
    cs = 1'b0;
    idle(3);

    // R10: commit dropped while busy
    frame(1'b0, 2'b11, 8'h08, 16'h0, 11, 0);
    chk("R10 first erase", int'(got_c), 1);
    frame(1'b0, 2'b11, 8'h09, 16'h0, 11, 0);
    chk("R10 erase during busy", int'(got_c), 0);
    idle(BUSY + 5);

    // R12: protection register write and clear
    frame(1'b1, 2'b01, 8'h22, 16'h0, 11, 0);
    chk("R12 prot write cmd", int'(got_c ? got_cmd : 4'd15), 9);
    idle(BUSY + 5);
    frame(1'b1, 2'b11, 8'h00, 16'h0, 11, 0);
    chk("R12 prot clear cmd", int'(got_c ? got_cmd : 4'd15), 10);
    idle(BUSY + 5);

    // R11: enable, other command, disable -> no lock
    frame(1'b1, 2'b00, 8'hC0, 16'h0, 11, 0); idle(BUSY + 5);
    frame(1'b0, 2'b10, 8'h00, 16'h0, 11, 0); idle(BUSY + 5);
    frame(1'b1, 2'b00, 8'h00, 16'h0, 11, 0); idle(BUSY + 5);
    frame(1'b0, 2'b11, 8'h01, 16'h0, 11, 0);
    cs = 1'b1; @(negedge clk);
    chk("R11 interrupted enable leaves unlocked", int'(sdo), 1);
    cs = 1'b0; idle(BUSY + 5);
    // enable immediately before disable -> lock
    frame(1'b1, 2'b00, 8'hC0, 16'h0, 11, 0); idle(BUSY + 5);
    frame(1'b1, 2'b00, 8'h00, 16'h0, 11, 0); idle(BUSY + 5);
    frame(1'b0, 2'b11, 8'h02, 16'h0, 11, 0);
    chk("R11 erase after lock commits", int'(got_c), 1);
    cs = 1'b1; @(negedge clk);
    chk("R11 locked hides busy", int'(sdo), 0);
    cs = 1'b0; idle(BUSY + 5);
    frame(1'b1, 2'b01, 8'h22, 16'h0, 11, 0); idle(BUSY + 5);
    chk("R12 prot write after lock", int'(got_c), 0);

    // R6: write disable blocks writes
    frame(1'b0, 2'b00, 8'h00, 16'h0, 11, 0); idle(BUSY + 5);
    frame(1'b0, 2'b01, 8'h10, 16'h0010, 27, 0); idle(BUSY + 5);
    chk("R6 write after disable", int'(got_c), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule